// File: doc/BRIEF.md
# Video Sync Period Measurement Unit

This block times the vertical sync and the horizontal or composite sync of an incoming video signal so that firmware can work out the video mode. A free-running 16-bit timer advances once every `TICK_DIV` clocks; at the default of 25 with a 50 MHz clock that gives 2 MHz, or 500 ns per count. Two capture channels latch the timer. Channel 1 watches vertical sync on a selectable edge. Channel 2 watches the falling edges of horizontal or composite sync, optionally through a divide-by-256 prescaler, so that one channel-2 period spans 256 lines and its resolution per line is about 1.95 ns.

All five sync and flyback inputs pass a two-flop synchroniser and an edge detector. Each falling edge sets a sticky presence bit that firmware clears. Each channel turns successive captures into a modulo-2^16 period. A per-channel filter publishes a stable period only after four consecutive measurements that each agree with the one before to within one count. Toggling the prescaler enable restarts the prescaler, so a composite-sync measurement can be lined up with a vertical pulse.

Top module: `sync_meas_unit`

## Requirements
- R1: A falling edge on hsync_i, vsync_i, csync_i, hfly_i or vfly_i sets presence bit 0, 1, 2, 3 or 4 of register 1. The bit holds until a write to register 1 with a 1 in that position clears it. A level held low after clearing does not set it again.
- R2: The timer at register 3 advances by exactly one every TICK_DIV clocks and wraps modulo 2^16.
- R3: Channel 1 captures on the vsync edge chosen by CTRL (register 0) bit 1: 1 selects rising, 0 selects falling. The other edge is ignored.
- R4: Channel 2 takes hsync_i when CTRL bit 2 is 0 and csync_i when it is 1. The unselected input causes no capture.
- R5: With CTRL bit 3 set, channel 2 captures on every 256th falling edge. With it clear, channel 2 captures on every falling edge.
- R6: Any change of CTRL bit 3 zeroes the prescaler count and discards the channel-2 reference, so the next capture comes after exactly 256 edges.
- R7: The period (register 6 for channel 1, register 7 for channel 2) is the modulo-2^16 difference of two consecutive captures. The first capture after CTRL bit 0 (run) is set, or after a resync, only stores a reference and clears that channel's stable-valid bit. Capture values are at registers 4 and 5.
- R8: Each capture sets flag bit 0 (channel 1) or bit 1 (channel 2) of register 2. A capture while that flag is still set sets overrun bit 2 or 3. Writing 1s to bits 0 to 3 of register 2 clears them.
- R9: irq_o is high when CTRL bit 4 is set and either capture flag is set.
- R10: Two periods match when they differ by at most TOL (1) count. After four consecutive matches the stable period (register 8 or 9) takes the latest value and valid bit 4 or 5 of register 2 is set. A mismatch restarts the count.
- R11: After reset every register, flag, presence bit and irq_o reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| csync_i | input | 1 | Composite sync |
| hfly_i | input | 1 | Horizontal flyback |
| vfly_i | input | 1 | Vertical flyback |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Capture interrupt request |

## Verification
On every cycle the assertions check these properties:
- The timer only ever steps by one.
- Presence bits stay set unless a clear write arrives, and a detected falling edge always lands in its bit.
- Prescaler pulses only appear with an edge, and a resync leaves a zero count.
- A capture against a set flag yields an overrun, and a reference-only capture yields no period.
- The stable period changes only when a period arrives.

Only the bench's scenarios can show the following:
- The actual period values for both vsync edge choices.
- The 256-edge spacing after a resync.
- Source selection between hsync and csync.
- The glitch and tolerance behaviour of the filter.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;
    localparam int TMR_W  = 16;
    localparam int REG_AW = 4;
    localparam int NSYNC  = 5;

    typedef logic [TMR_W-1:0] tick_t;

    // packed: first field is the MSB, so run sits in bit 0
    typedef struct packed {
        logic irq_en;
        logic presc_en;
        logic h_comp;
        logic v_rise;
        logic run;
    } ctrl_t;

    localparam logic [REG_AW-1:0] A_CTRL = 4'd0;
    localparam logic [REG_AW-1:0] A_PRES = 4'd1;
    localparam logic [REG_AW-1:0] A_FLAG = 4'd2;
    localparam logic [REG_AW-1:0] A_TMR  = 4'd3;
    localparam logic [REG_AW-1:0] A_CAP1 = 4'd4;
    localparam logic [REG_AW-1:0] A_CAP2 = 4'd5;
    localparam logic [REG_AW-1:0] A_PER1 = 4'd6;
    localparam logic [REG_AW-1:0] A_PER2 = 4'd7;
    localparam logic [REG_AW-1:0] A_STB1 = 4'd8;
    localparam logic [REG_AW-1:0] A_STB2 = 4'd9;

    localparam int P_HS = 0;
    localparam int P_VS = 1;
    localparam int P_CS = 2;
    localparam int P_HF = 3;
    localparam int P_VF = 4;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] sh;
        logic [N-1:0]             prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sh[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.sh[STAGES-1];
    assign rise_o = ~st_q.prev & st_q.sh[STAGES-1];
endmodule

// File: rtl/sync_prescaler.sv
module sync_prescaler #(
    parameter int PW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic edge_i,
    output logic pulse_o,
    output logic resync_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          en_prev;
    } psc_st_t;

    psc_st_t st_d, st_q;

    assign resync_o = (en_i != st_q.en_prev);

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_i;
        if (resync_o)            st_d.cnt = '0;
        else if (en_i && edge_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = en_i ? (edge_i && !resync_o && (st_q.cnt == '1)) : edge_i;

    assert_presc_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> edge_i);
    assert_resync_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |=> (st_q.cnt == '0));
endmodule

// File: rtl/sync_cap_chan.sv
module sync_cap_chan
    import sync_meas_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  logic  resync_i,
    input  logic  evt_i,
    input  tick_t timer_i,
    input  logic  flag_clr_i,
    input  logic  ovr_clr_i,
    output tick_t cap_o,
    output tick_t period_o,
    output logic  pvld_o,
    output logic  flag_o,
    output logic  ovr_o,
    output logic  restart_o
);
    typedef struct packed {
        tick_t cap;
        tick_t period;
        logic  pvld;
        logic  ref_ok;
        logic  flag;
        logic  ovr;
    } ch_st_t;

    ch_st_t st_d, st_q;

    assign restart_o = !run_i || resync_i;

    always_comb begin
        st_d      = st_q;
        st_d.pvld = 1'b0;
        if (flag_clr_i) st_d.flag = 1'b0;
        if (ovr_clr_i)  st_d.ovr  = 1'b0;
        if (restart_o) begin
            st_d.ref_ok = 1'b0;
        end else if (evt_i) begin
            st_d.cap    = timer_i;
            st_d.ref_ok = 1'b1;
            if (st_q.ref_ok) begin
                st_d.period = timer_i - st_q.cap;
                st_d.pvld   = 1'b1;
            end
            if (st_q.flag && !flag_clr_i) st_d.ovr = 1'b1;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o    = st_q.cap;
    assign period_o = st_q.period;
    assign pvld_o   = st_q.pvld;
    assign flag_o   = st_q.flag;
    assign ovr_o    = st_q.ovr;

    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !restart_o && flag_o && !flag_clr_i) |=> ovr_o);
    assert_flag_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !restart_o) |=> flag_o);
    assert_ref_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !restart_o && !st_q.ref_ok) |=> !pvld_o);
endmodule

// File: rtl/sync_period_filter.sv
module sync_period_filter
    import sync_meas_pkg::*;
#(
    parameter int MATCH_N = 4,
    parameter int TOL     = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart_i,
    input  logic  pvld_i,
    input  tick_t period_i,
    output tick_t stable_o,
    output logic  valid_o
);
    localparam int CNT_W = $clog2(MATCH_N + 1);

    typedef struct packed {
        tick_t            last;
        tick_t            stable;
        logic [CNT_W-1:0] cnt;
        logic             have;
        logic             valid;
    } flt_st_t;

    flt_st_t st_d, st_q;
    tick_t   diff_up, diff_dn;
    logic    close;

    always_comb begin
        diff_up = period_i - st_q.last;
        diff_dn = st_q.last - period_i;
        close   = (diff_up <= tick_t'(TOL)) || (diff_dn <= tick_t'(TOL));
        st_d    = st_q;
        if (restart_i) begin
            st_d = '0;
        end else if (pvld_i) begin
            st_d.last = period_i;
            if (!st_q.have) begin
                st_d.have = 1'b1;
                st_d.cnt  = '0;
            end else if (close) begin
                if (st_q.cnt == CNT_W'(MATCH_N - 1)) begin
                    st_d.stable = period_i;
                    st_d.valid  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stable_o = st_q.stable;
    assign valid_o  = st_q.valid;

    assert_valid_needs_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(pvld_i));
    assert_stable_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pvld_i && !restart_i) |=> $stable(stable_o));
endmodule

// File: rtl/sync_meas_unit.sv
module sync_meas_unit
    import sync_meas_pkg::*;
#(
    parameter int TICK_DIV    = 25,
    parameter int PRESC_W     = 8,
    parameter int MATCH_N     = 4,
    parameter int TOL         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              csync_i,
    input  logic              hfly_i,
    input  logic              vfly_i,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [TMR_W-1:0]  reg_wdata,
    output logic [TMR_W-1:0]  reg_rdata,
    output logic              irq_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [NSYNC-1:0]  pres;
        logic [DIV_W-1:0]  div;
        tick_t             timer;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSYNC-1:0] raw, fall, rise;
    logic wr_ctrl, wr_pres, wr_flag;
    logic ch1_evt, h_fall, ch2_evt, ch2_resync;
    tick_t cap1, cap2, per1, per2, stb1, stb2;
    logic pv1, pv2, flag1, flag2, ovr1, ovr2, rs1, rs2, val1, val2;

    assign raw     = {vfly_i, hfly_i, csync_i, vsync_i, hsync_i};
    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign wr_pres = reg_we && (reg_addr == A_PRES);
    assign wr_flag = reg_we && (reg_addr == A_FLAG);

    sync_edge_det #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(raw), .fall_o(fall), .rise_o(rise));

    assign ch1_evt = st_q.ctrl.v_rise ? rise[P_VS] : fall[P_VS];
    assign h_fall  = st_q.ctrl.h_comp ? fall[P_CS] : fall[P_HS];

    sync_prescaler #(.PW(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en_i(st_q.ctrl.presc_en), .edge_i(h_fall),
        .pulse_o(ch2_evt), .resync_o(ch2_resync));

    sync_cap_chan u_ch1 (
        .clk(clk), .rst_n(rst_n), .run_i(st_q.ctrl.run), .resync_i(1'b0),
        .evt_i(ch1_evt), .timer_i(st_q.timer),
        .flag_clr_i(wr_flag && reg_wdata[0]), .ovr_clr_i(wr_flag && reg_wdata[2]),
        .cap_o(cap1), .period_o(per1), .pvld_o(pv1), .flag_o(flag1), .ovr_o(ovr1),
        .restart_o(rs1));

    sync_cap_chan u_ch2 (
        .clk(clk), .rst_n(rst_n), .run_i(st_q.ctrl.run), .resync_i(ch2_resync),
        .evt_i(ch2_evt), .timer_i(st_q.timer),
        .flag_clr_i(wr_flag && reg_wdata[1]), .ovr_clr_i(wr_flag && reg_wdata[3]),
        .cap_o(cap2), .period_o(per2), .pvld_o(pv2), .flag_o(flag2), .ovr_o(ovr2),
        .restart_o(rs2));

    sync_period_filter #(.MATCH_N(MATCH_N), .TOL(TOL)) u_flt1 (
        .clk(clk), .rst_n(rst_n), .restart_i(rs1), .pvld_i(pv1), .period_i(per1),
        .stable_o(stb1), .valid_o(val1));

    sync_period_filter #(.MATCH_N(MATCH_N), .TOL(TOL)) u_flt2 (
        .clk(clk), .rst_n(rst_n), .restart_i(rs2), .pvld_i(pv2), .period_i(per2),
        .stable_o(stb2), .valid_o(val2));

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(reg_wdata[4:0]);
        // a new edge wins over a clear in the same cycle
        st_d.pres = (st_q.pres & ~(wr_pres ? reg_wdata[NSYNC-1:0] : '0)) | fall;
        if (st_q.div == DIV_W'(TICK_DIV - 1)) begin
            st_d.div   = '0;
            st_d.timer = st_q.timer + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = TMR_W'(st_q.ctrl);
            A_PRES:  reg_rdata = TMR_W'(st_q.pres);
            A_FLAG:  reg_rdata = TMR_W'({val2, val1, ovr2, ovr1, flag2, flag1});
            A_TMR:   reg_rdata = st_q.timer;
            A_CAP1:  reg_rdata = cap1;
            A_CAP2:  reg_rdata = cap2;
            A_PER1:  reg_rdata = per1;
            A_PER2:  reg_rdata = per2;
            A_STB1:  reg_rdata = stb1;
            A_STB2:  reg_rdata = stb2;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_o = st_q.ctrl.irq_en && (flag1 || flag2);

    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.timer != $past(st_q.timer)) |-> (st_q.timer == $past(st_q.timer) + 1'b1));
    assert_presence_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pres |=> ((st_q.pres & $past(st_q.pres)) == $past(st_q.pres)));
    assert_presence_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((st_q.pres & $past(fall)) == $past(fall)));
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> st_q.ctrl.irq_en);
endmodule

// File: tb/test_sync_meas_unit.sv
module test_sync_meas_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b1, vsync = 1'b1, csync = 1'b1, hfly = 1'b1, vfly = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    sync_meas_unit #(.TICK_DIV(4)) i_sync_meas_unit (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync), .csync_i(csync),
        .hfly_i(hfly), .vfly_i(vfly), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq));

    // {vsync period in clocks, rising select, expected counts}
    localparam int VEC [5][3] = '{
        '{400, 0, 100}, '{400, 1, 100}, '{800, 0, 200}, '{1000, 1, 250}, '{2000, 0, 500}};

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic v_period(input int gap);
        vsync = 1'b0;
        repeat (8) @(negedge clk);
        vsync = 1'b1;
        repeat (gap - 8) @(negedge clk);
    endtask

    task automatic h_edges(input int n, input bit comp);
        for (int i = 0; i < n; i++) begin
            if (comp) csync = 1'b0; else hsync = 1'b0;
            repeat (4) @(negedge clk);
            if (comp) csync = 1'b1; else hsync = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic restart_ch1(input logic [15:0] ctrl);
        wr(4'd0, 16'h0000);
        wr(4'd0, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, t0, t1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 reset state
        rd(4'd0, v); chk("R11 ctrl after reset", v, 0);
        rd(4'd1, v); chk("R11 presence after reset", v, 0);
        rd(4'd2, v); chk("R11 flags after reset", v, 0);
        rd(4'd8, v); chk("R11 stable1 after reset", v, 0);
        chk("R11 irq after reset", int'(irq), 0);

        // R2 timer rate
        rd(4'd3, t0);
        repeat (39) @(negedge clk);
        rd(4'd3, t1);
        chk("R2 timer advance over 40 clocks", (t1 - t0) & 16'hFFFF, 10);

        // R1 presence latches
        hfly = 1'b0; repeat (6) @(negedge clk);
        rd(4'd1, v); chk("R1 hfly presence", v, 8);
        vfly = 1'b0; repeat (6) @(negedge clk);
        rd(4'd1, v); chk("R1 vfly presence", v, 24);
        wr(4'd1, 16'h0008); repeat (4) @(negedge clk);
        rd(4'd1, v); chk("R1 clear hfly only, low level does not reset", v, 16);
        hfly = 1'b1; vfly = 1'b1;

        // R3, R7, R10 table of vsync periods
        for (int k = 0; k < 5; k++) begin
            restart_ch1(16'h0001 | 16'(VEC[k][1] << 1));
            rd(4'd2, v); chk("R7 restart clears valid1", (v >> 4) & 1, 0);
            for (int j = 0; j < 6; j++) v_period(VEC[k][0]);
            rd(4'd6, v); chk("R7 vsync period", v, VEC[k][2]);
            rd(4'd8, v); chk("R10 stable vsync period", v, VEC[k][2]);
            rd(4'd2, v); chk("R10 valid1 after four matches", (v >> 4) & 1, 1);
        end

        // R3 rising select ignores falling edge
        wr(4'd0, 16'h0003); wr(4'd2, 16'h000F);
        vsync = 1'b0; repeat (10) @(negedge clk);
        rd(4'd2, v); chk("R3 falling edge ignored with rising select", v & 1, 0);
        vsync = 1'b1; repeat (10) @(negedge clk);
        rd(4'd2, v); chk("R3 rising edge captures", v & 1, 1);

        // R8 overrun and R9 irq
        wr(4'd0, 16'h0001); wr(4'd2, 16'h000F);
        v_period(40); v_period(40);
        rd(4'd2, v); chk("R8 capture flag1", v & 1, 1);
        chk("R8 overrun1", (v >> 2) & 1, 1);
        chk("R9 irq masked", int'(irq), 0);
        wr(4'd0, 16'h0011); @(negedge clk);
        chk("R9 irq enabled", int'(irq), 1);
        wr(4'd2, 16'h0005); @(negedge clk);
        chk("R9 irq after flag clear", int'(irq), 0);
        rd(4'd2, v); chk("R8 flag and overrun cleared", v & 5, 0);

        // R10 glitch restarts the match count
        restart_ch1(16'h0001);
        for (int i = 0; i < 9; i++) v_period(i == 3 ? 480 : 400);
        rd(4'd2, v); chk("R10 mismatch restarts count", (v >> 4) & 1, 0);
        v_period(400);
        rd(4'd2, v); chk("R10 valid after fresh four matches", (v >> 4) & 1, 1);
        rd(4'd8, v); chk("R10 stable after glitch", v, 100);

        // R10 tolerance of one count
        restart_ch1(16'h0001);
        for (int i = 0; i < 6; i++) v_period((i % 2) ? 404 : 400);
        rd(4'd2, v); chk("R10 plus-minus one accepted", (v >> 4) & 1, 1);
        rd(4'd8, v); chk("R10 stable within tolerance", v, 100);
        restart_ch1(16'h0001);
        for (int i = 0; i < 6; i++) v_period((i % 2) ? 408 : 400);
        rd(4'd2, v); chk("R10 two counts rejected", (v >> 4) & 1, 0);

        // R5 prescaled horizontal measurement
        wr(4'd0, 16'h0009); wr(4'd2, 16'h000F);
        h_edges(1536, 1'b0);
        rd(4'd7, v); chk("R5 prescaled period 256 lines", v, 512);
        rd(4'd9, v); chk("R5 stable2 prescaled", v, 512);
        rd(4'd2, v); chk("R10 valid2", (v >> 5) & 1, 1);
        rd(4'd1, v); chk("R1 hsync presence", v & 1, 1);

        // R6 resync by toggling prescaler enable
        wr(4'd0, 16'h0001); wr(4'd0, 16'h0009); wr(4'd2, 16'h000F);
        h_edges(255, 1'b0);
        rd(4'd2, v); chk("R6 no capture before 256 edges", (v >> 1) & 1, 0);
        h_edges(1, 1'b0);
        rd(4'd2, v); chk("R6 capture on 256th edge", (v >> 1) & 1, 1);
        chk("R7 reference only after resync", (v >> 5) & 1, 0);

        // R5 prescaler off captures every edge
        wr(4'd0, 16'h0001);
        h_edges(3, 1'b0);
        rd(4'd7, v); chk("R5 unprescaled period", v, 2);

        // R4 source select
        wr(4'd0, 16'h0005); wr(4'd2, 16'h000F);
        h_edges(3, 1'b0);
        rd(4'd2, v); chk("R4 hsync ignored with csync selected", (v >> 1) & 1, 0);
        h_edges(3, 1'b1);
        rd(4'd7, v); chk("R4 csync period", v, 2);
        rd(4'd1, v); chk("R1 csync presence", (v >> 2) & 1, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule